// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds a small bank of hardware tokens that two independent agents, a left port and a right port, use to reserve shared resources. A port claims a token by writing a 0 to it. It releases the token, or withdraws a claim it has not yet been granted, by writing a 1. Only data bit 0 carries the command. At most one port holds a given token at any moment. A claim made while the other port holds the token is remembered. When the holder releases the token, it passes to the waiting port at that same clock edge, so the waiting port never has to retry.

Each port reads the token from its own side. A read returns 0 if that port holds the token and 1 if it does not, and the bit is repeated on every data line. The read value is captured in a per-port output register at the clock edge that accepts the read. It shows the token as it stood before any write accepted at that same edge, and it stays unchanged until the port's next read. An access is selected by a semaphore select. The port's main-memory enable must be low, because the memory enable takes priority and turns the cycle into a non-semaphore one. The low address bits pick the token and the remaining address bits are ignored. Every access is accepted in the cycle it is presented. There is no back-pressure, so there is no ready signal.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every token is free, and both read registers hold all ones.
- R2: The token is selected by address bits [2:0] (with NUM_SEM = 8). The upper address bits have no effect on which token is written or read.
- R3: An access takes place only when sem_sel = 1 and mem_en = 0. A write with mem_en = 1 or sem_sel = 0 leaves every token unchanged. A read with mem_en = 1 leaves the read register unchanged.
- R4: Writing bit 0 = 0 to a free token grants it to the writer. From then on the writer reads 0 and the other port reads 1. Data bits above bit 0 are ignored.
- R5: A 0 written by the port that does not hold the token leaves both ports' views unchanged. The claim is recorded as pending.
- R6: When the holder writes 1 while the other port has a pending claim, the token passes to the other port at that same clock edge.
- R7: When the holder writes 1 and no claim is pending, the token becomes free and both ports read 1.
- R8: A 1 written by a non-holder withdraws its pending claim. If no claim is pending, it changes nothing.
- R9: A read (sem_sel = 1, mem_en = 0, wr = 0, oe = 1) loads the port's view into its read register, repeated on all DATA_W bits. The value is visible after that clock edge and reflects the state before any write accepted at the same edge. It is held until the port's next read.
- R10: When both ports write 0 to a free token in the same cycle, the left port gets the token and the right port's claim becomes pending.
- R11: No token ever reads 0 on both ports at once.
- R12: A write accepted at one edge is visible to a read accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left main-memory enable; blocks semaphore access when 1 |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable for reads |
| l_addr | input | ADDR_W | Left address; low bits select the token |
| l_wdata | input | DATA_W | Left write data; bit 0 is the command |
| l_rdata | output | DATA_W | Left read register |
| r_sem_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right main-memory enable; blocks semaphore access when 1 |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read register |

## Verification
Two things can happen to the same token at one clock edge. The holder can release it while the other port claims it or reads it, and both ports can claim a free token together. The bench provokes these with an exhaustive sweep. Every pair of left and right operations is applied to each token, and each pair is followed by a read on both ports. A seeded pseudo-random run with random upper address and data bits comes after the sweep. The bench judges every cycle against its own model of holder and pending claims. Directed cases add literal checks for the handover and left-priority outcomes and for a read that races a release.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // Holder of one token
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } sem_holder_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 9,
  parameter int IDX_W  = 3
) (
  input  logic              sem_sel,
  input  logic              mem_en,
  input  logic              wr,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  idx,
  output logic              wbit
);
  logic access;
  logic dropped_zero;

  // memory enable has priority over semaphore select
  assign access = sem_sel & ~mem_en;
  assign wr_hit = access & wr;
  assign rd_hit = access & ~wr & oe;
  assign idx    = addr[IDX_W-1:0];

  // upper address and data bits carry no meaning; fold them to a constant 0
  assign dropped_zero = &{1'b0, addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
  assign wbit = wdata[0] | dropped_zero;
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic bit_l,
  input  logic wr_r,
  input  logic bit_r,
  output logic view_l,
  output logic view_r
);
  sem_holder_e holder, holder_nx;
  logic        want_l, want_r;
  logic        want_l_nx, want_r_nx;

  always_comb begin
    want_l_nx = wr_l ? ~bit_l : want_l;
    want_r_nx = wr_r ? ~bit_r : want_r;
    unique case (holder)
      HOLD_LEFT:
        holder_nx = want_l_nx ? HOLD_LEFT :
                    (want_r_nx ? HOLD_RIGHT : HOLD_NONE);
      HOLD_RIGHT:
        holder_nx = want_r_nx ? HOLD_RIGHT :
                    (want_l_nx ? HOLD_LEFT : HOLD_NONE);
      default:
        holder_nx = want_l_nx ? HOLD_LEFT :
                    (want_r_nx ? HOLD_RIGHT : HOLD_NONE);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holder <= HOLD_NONE;
      want_l <= 1'b0;
      want_r <= 1'b0;
    end else begin
      holder <= holder_nx;
      want_l <= want_l_nx;
      want_r <= want_r_nx;
    end
  end

  assign view_l = (holder != HOLD_LEFT);
  assign view_r = (holder != HOLD_RIGHT);
endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_hit,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] views,
  output logic [DATA_W-1:0]  rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '1;
    else if (rd_hit) rdata <= {DATA_W{views[idx]}};
  end
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_sel,
  input  logic              l_mem_en,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_sel,
  input  logic              r_mem_en,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

  logic             l_wr_hit, l_rd_hit, l_bit;
  logic             r_wr_hit, r_rd_hit, r_bit;
  logic [IDX_W-1:0] l_idx, r_idx;
  logic [NUM_SEM-1:0] view_l, view_r;

  sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_l (
    .sem_sel(l_sem_sel), .mem_en(l_mem_en), .wr(l_wr), .oe(l_oe),
    .addr(l_addr), .wdata(l_wdata),
    .wr_hit(l_wr_hit), .rd_hit(l_rd_hit), .idx(l_idx), .wbit(l_bit)
  );

  sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_r (
    .sem_sel(r_sem_sel), .mem_en(r_mem_en), .wr(r_wr), .oe(r_oe),
    .addr(r_addr), .wdata(r_wdata),
    .wr_hit(r_wr_hit), .rd_hit(r_rd_hit), .idx(r_idx), .wbit(r_bit)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_sem
    logic hit_l, hit_r;
    assign hit_l = l_wr_hit && (l_idx == IDX_W'(g));
    assign hit_r = r_wr_hit && (r_idx == IDX_W'(g));

    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_l(hit_l), .bit_l(l_bit),
      .wr_r(hit_r), .bit_r(r_bit),
      .view_l(view_l[g]), .view_r(view_r[g])
    );
  end

  sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd_hit(l_rd_hit), .idx(l_idx),
    .views(view_l), .rdata(l_rdata)
  );

  sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd_hit(r_rd_hit), .idx(r_idx),
    .views(view_r), .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_token_bank_chk.sv
module sem_token_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 9,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_sem_sel,
  input logic               l_mem_en,
  input logic               l_wr,
  input logic               l_oe,
  input logic [IDX_W-1:0]   l_idx,
  input logic               l_bit,
  input logic               r_sem_sel,
  input logic               r_mem_en,
  input logic               r_wr,
  input logic               r_oe,
  input logic [DATA_W-1:0]  l_rdata,
  input logic [DATA_W-1:0]  r_rdata,
  input logic [NUM_SEM-1:0] view_l,
  input logic [NUM_SEM-1:0] view_r
);
  logic               l_write, l_read, r_read;
  logic [NUM_SEM-1:0] l_onehot, l_rel, l_req;

  assign l_write  = l_sem_sel && !l_mem_en && l_wr;
  assign l_read   = l_sem_sel && !l_mem_en && !l_wr && l_oe;
  assign r_read   = r_sem_sel && !r_mem_en && !r_wr && r_oe;
  assign l_onehot = NUM_SEM'(1) << l_idx;
  assign l_rel    = (l_write &&  l_bit) ? l_onehot : '0;
  assign l_req    = (l_write && !l_bit) ? l_onehot : '0;

  // R11: never two holders
  assert_single_holder_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (~view_l & ~view_r) == '0);

  // R9: read register always a replicated bit
  assert_read_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  // R3: no read accepted, register keeps its value
  assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_read || r_read) |=> ($stable(l_rdata) && $stable(r_rdata)));

  // R5: a left-held token stays held unless the left port releases it
  assert_keep_holder_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~view_l & ~l_rel) & view_l) == '0));

  // R4: a left claim on a free token is granted at the next edge
  assert_free_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(l_req & view_l & view_r) & view_l) == '0));
endmodule

bind sem_token_bank sem_token_bank_chk #(
  .NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_oe(l_oe),
  .l_idx(l_addr[IDX_W-1:0]), .l_bit(l_wdata[0]),
  .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_oe(r_oe),
  .l_rdata(l_rdata), .r_rdata(r_rdata),
  .view_l(view_l), .view_r(view_r)
);

// File: tb/sim_sem_token_bank.sv
module sim_sem_token_bank;
  localparam int PERIOD = 10;
  localparam int NS = 8;
  localparam int AW = 15;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic l_sem_sel, l_mem_en, l_wr, l_oe;
  logic r_sem_sel, r_mem_en, r_wr, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  always #(PERIOD/2) clk = ~clk;

  sem_token_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_oe(l_oe),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_oe(r_oe),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag;
  // model: holder 0 none, 1 left, 2 right; claim flags per port
  int holder[NS];
  bit cl_l[NS], cl_r[NS];
  logic [DW-1:0] hold_l, hold_r;
  logic [31:0] rng = 32'h1ace5eed;

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // op: 0 idle, 1 write, 2 read, 3 write with mem_en, 4 write without select, 5 read with mem_en
  function automatic logic [3:0] pins(input int op);
    case (op)
      1: return 4'b1010;
      2: return 4'b1001;
      3: return 4'b1110;
      4: return 4'b0011;
      5: return 4'b1101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic void settle(input int i);
    case (holder[i])
      1: holder[i] = cl_l[i] ? 1 : (cl_r[i] ? 2 : 0);
      2: holder[i] = cl_r[i] ? 2 : (cl_l[i] ? 1 : 0);
      default: holder[i] = cl_l[i] ? 1 : (cl_r[i] ? 2 : 0);
    endcase
  endfunction

  task automatic step(input int lop, input int ls, input logic [DW-1:0] ld,
                      input int rop, input int rs, input logic [DW-1:0] rd);
    logic [3:0] lp, rp;
    logic el, er;
    lp = pins(lop);
    rp = pins(rop);
    {l_sem_sel, l_mem_en, l_wr, l_oe} = lp;
    {r_sem_sel, r_mem_en, r_wr, r_oe} = rp;
    l_addr = {rnd()[AW-4:0], 3'(ls)};   // random upper bits (R2)
    r_addr = {rnd()[AW-4:0], 3'(rs)};
    l_wdata = ld;
    r_wdata = rd;
    el = (holder[ls] == 1) ? 1'b0 : 1'b1;
    er = (holder[rs] == 2) ? 1'b0 : 1'b1;
    if (lop == 1) cl_l[ls] = ~ld[0];
    if (rop == 1) cl_r[rs] = ~rd[0];
    for (int i = 0; i < NS; i++) settle(i);
    @(posedge clk);
    @(negedge clk);
    if (lop == 2) hold_l = {DW{el}};
    if (rop == 2) hold_r = {DW{er}};
    chk({tag, " left"}, l_rdata, hold_l);
    chk({tag, " right"}, r_rdata, hold_r);
  endtask

  task automatic do_reset();
    {l_sem_sel, l_mem_en, l_wr, l_oe} = 4'b0;
    {r_sem_sel, r_mem_en, r_wr, r_oe} = 4'b0;
    l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    rst_n = 1'b0;
    for (int i = 0; i < NS; i++) begin
      holder[i] = 0; cl_l[i] = 0; cl_r[i] = 0;
    end
    hold_l = '1;
    hold_r = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset left", l_rdata, '1);
    chk("R1 reset right", r_rdata, '1);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    tag = "R1 all free";
    for (int s = 0; s < NS; s++) step(2, s, '0, 2, s, '0);

    // R4: left claims token 2, upper data bits set
    tag = "R4 grant";
    step(1, 2, 9'h1fe, 0, 0, '0);
    step(2, 2, '0, 2, 2, '0);
    chk("R4 left holds", l_rdata, 9'h000);
    chk("R4 right sees", r_rdata, 9'h1ff);
    // R4: right claims token 5 with bit0 = 0
    step(0, 0, '0, 1, 5, 9'h0fe);
    // R2 / R12: left claims token 6, reads differ only in upper bits
    tag = "R2 addr";
    step(1, 6, 9'h000, 0, 0, '0);
    step(2, 6, '0, 2, 6, '0);
    chk("R2 left holds 6", l_rdata, 9'h000);
    chk("R12 right sees 6", r_rdata, 9'h1ff);

    // R5: right claims token 2 held by left
    tag = "R5 blocked claim";
    step(0, 0, '0, 1, 2, 9'h000);
    step(2, 2, '0, 2, 2, '0);
    chk("R5 right still out", r_rdata, 9'h1ff);
    // R6: left releases, right takes over
    tag = "R6 handover";
    step(1, 2, 9'h001, 0, 0, '0);
    step(2, 2, '0, 2, 2, '0);
    chk("R6 right holds", r_rdata, 9'h000);
    chk("R6 left out", l_rdata, 9'h1ff);
    // R7: right releases, free
    tag = "R7 free";
    step(0, 0, '0, 1, 2, 9'h001);
    step(2, 2, '0, 2, 2, '0);
    chk("R7 right free", r_rdata, 9'h1ff);
    // R8: cancel a pending claim
    tag = "R8 cancel";
    step(1, 2, 9'h000, 0, 0, '0);
    step(0, 0, '0, 1, 2, 9'h000);
    step(0, 0, '0, 1, 2, 9'h001);
    step(1, 2, 9'h001, 0, 0, '0);
    step(2, 2, '0, 2, 2, '0);
    chk("R8 cancelled claim not granted", r_rdata, 9'h1ff);
    // R8: non-holder release without claim changes nothing
    step(0, 0, '0, 1, 6, 9'h001);
    step(2, 6, '0, 0, 0, '0);
    chk("R8 left keeps 6", l_rdata, 9'h000);

    // R10: same-cycle claims on free token 7
    tag = "R10 tie";
    step(1, 7, 9'h000, 1, 7, 9'h000);
    step(2, 7, '0, 2, 7, '0);
    chk("R10 left wins", l_rdata, 9'h000);
    chk("R10 right out", r_rdata, 9'h1ff);
    step(1, 7, 9'h001, 0, 0, '0);
    step(0, 0, '0, 2, 7, '0);
    chk("R10 right pending granted", r_rdata, 9'h000);

    // R3: blocked writes and reads
    tag = "R3 blocked";
    step(3, 0, 9'h000, 4, 0, 9'h000);
    step(2, 0, '0, 2, 0, '0);
    chk("R3 token 0 free", l_rdata, 9'h1ff);
    step(1, 0, 9'h000, 0, 0, '0);
    step(5, 0, '0, 5, 0, '0);
    chk("R3 blocked read holds", l_rdata, 9'h1ff);

    // R9: left read races right release of token 5 (left pending)
    tag = "R9 race";
    step(1, 5, 9'h000, 0, 0, '0);
    step(2, 5, '0, 1, 5, 9'h001);
    chk("R9 old view", l_rdata, 9'h1ff);
    step(0, 0, '0, 0, 0, '0);
    chk("R9 held", l_rdata, 9'h1ff);
    step(2, 5, '0, 0, 0, '0);
    chk("R9 new view", l_rdata, 9'h000);

    // exhaustive operation pairs on each token
    do_reset();
    tag = "R11 pair sweep";
    for (int s = 0; s < NS; s++)
      for (int lo = 0; lo < 6; lo++)
        for (int ro = 0; ro < 6; ro++) begin
          step(lo, s, DW'(rnd()), ro, s, DW'(rnd()));
          step(2, s, '0, 2, s, '0);
        end

    // pseudo-random traffic
    do_reset();
    tag = "R9 random";
    for (int n = 0; n < 2000; n++)
      step(int'(rnd() % 6), int'(rnd() % NS), DW'(rnd()),
           int'(rnd() % 6), int'(rnd() % NS), DW'(rnd()));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule